// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block turns one of many raw request lines into a service request for a single DMA channel. A 5-bit selection code picks the line. The candidates are four external request pins, the completion strobes of six DMA channels, and thirteen status flags from on-chip peripherals. Every chosen line is treated as a synchronous, edge-sensitive input. A rising transition raises a pending trigger, and that trigger is held until the priority arbiter grants it.

Some peripheral sources can use a faster handshake, and a parameter mask marks which ones. When such a source is selected and the channel moves single words, the block drives a ready line to the peripheral. The peripheral answers with one-cycle pulses. Each pulse drops the ready line, and a grant raises it again at once. This allows one trigger every two clocks, and pulses that arrive while earlier triggers are still pending are counted instead of merged.

Top module: `dma_trig_select`

## Requirements
- R1: While reset is applied and directly after it is released, `trig` and `fast_rdy` are low.
- R2: Codes 0, 1, 2 and 3 select `ext_req[0]`, `ext_req[1]`, `ext_req[2]` and `ext_req[3]`. A rise on any line that is not selected produces no trigger.
- R3: Codes 4 to 9 select `chan_done[0]` to `chan_done[5]`, in that order.
- R4: Codes 10 to 22 select `periph_req[code-10]`. Codes 23 to 31 never raise a trigger, whatever the lines do.
- R5: A trigger is raised only by a low-to-high change of the selected line, seen in two consecutive clock samples. `trig` goes high one cycle after the high sample. A line that stays high raises no further trigger.
- R6: When `src_sel` changes, the line it now names is taken as the new reference. A line that is already high at the switch raises no trigger.
- R7: A pending trigger keeps `trig` high until `grant` is sampled high. It is cleared on that clock edge unless a new edge is seen in the same cycle.
- R8: For a source in regular mode, any number of edges seen while a trigger is pending count as one, and one grant clears them.
- R9: Fast mode applies when `FAST_MASK[code]` is set (by default codes 18 to 21) and `xfer_mode` is 3'b001 or 3'b101. In fast mode with no trigger pending, `fast_rdy` is high. Outside fast mode, `fast_rdy` is low one cycle later.
- R10: In fast mode, a pulse on the selected line that arrives without a grant drives `fast_rdy` low on the next cycle. A grant drives `fast_rdy` high on the next cycle.
- R11: In fast mode, up to `FAST_DEPTH` pulses (3 by default) are held pending, and each one needs its own grant.
- R12: A fast-capable source used with any other `xfer_mode` behaves as a regular source: `fast_rdy` stays low, and edges that arrive while a trigger is pending merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 5 | Request source code |
| xfer_mode | input | 3 | Channel transfer-mode field |
| ext_req | input | 4 | External request pins |
| chan_done | input | 6 | Transfer-complete strobes of channels 0 to 5 |
| periph_req | input | 13 | Peripheral request flags |
| grant | input | 1 | Arbiter accepts the pending trigger |
| trig | output | 1 | Trigger pending toward the transfer engine |
| fast_rdy | output | 1 | Ready line to a fast-handshake peripheral |

## Verification
Each result is due exactly one clock after its cause is sampled. A line that rises at one edge shows `trig` high after that edge. A grant clears `trig` at the edge that samples it. A pulse or a grant moves `fast_rdy` at the same edge. A change of source needs one edge to reload the reference. The bench changes inputs only on falling edges and reads outputs on the next falling edge, so each check falls half a cycle after the single register stage it depends on. Negative checks on held-high lines and on source switches are repeated for a second cycle to show that no late trigger appears.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

    localparam logic [2:0] XFER_WORD_A = 3'b001;
    localparam logic [2:0] XFER_WORD_B = 3'b101;

    // Word-transfer modes are the only ones that allow the fast handshake
    function automatic logic is_word_mode(input logic [2:0] mode);
        return (mode == XFER_WORD_A) || (mode == XFER_WORD_B);
    endfunction

endpackage

// File: rtl/dma_src_mux.sv
module dma_src_mux #(
    parameter int          N_EXT     = 4,
    parameter int          N_CHAN    = 6,
    parameter int          N_PERIPH  = 13,
    parameter int          SRC_W     = 5,
    parameter logic [31:0] FAST_MASK = 32'h003C_0000
) (
    input  logic [N_EXT-1:0]    ext_req,
    input  logic [N_CHAN-1:0]   chan_done,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic [SRC_W-1:0]    src_sel,
    output logic                sel_line,
    output logic                fast_cap
);
    localparam int N_SRC  = N_EXT + N_CHAN + N_PERIPH;
    localparam int N_CODE = 1 << SRC_W;

    logic [N_SRC-1:0]  flat_lines;
    logic [N_CODE-1:0] line_vec;
    logic [N_CODE-1:0] cap_vec;

    assign flat_lines = {periph_req, chan_done, ext_req};

    // Codes beyond the last real source are reserved and tie to zero
    for (genvar i = 0; i < N_CODE; i++) begin : g_code
        if (i < N_SRC) begin : g_used
            assign line_vec[i] = flat_lines[i];
            assign cap_vec[i]  = FAST_MASK[i];
        end else begin : g_rsvd
            assign line_vec[i] = 1'b0;
            assign cap_vec[i]  = 1'b0;
        end
    end

    assign sel_line = line_vec[src_sel];
    assign fast_cap = cap_vec[src_sel];

endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dma_trig_pkg::*;
#(
    parameter int SRC_W      = 5,
    parameter int FAST_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             sel_line,
    input  logic             fast_cap,
    input  logic [2:0]       xfer_mode,
    input  logic             grant,
    output logic             trig,
    output logic             fast_rdy
);
    localparam int CNT_W = $clog2(FAST_DEPTH + 1);

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             rdy;
    } ctrl_t;

    ctrl_t            st_q, st_d;
    logic             fast_mode;
    logic             src_same;
    logic             edge_hit;
    logic [CNT_W-1:0] cnt_lim;

    always_comb begin
        fast_mode = fast_cap && is_word_mode(xfer_mode);
        src_same  = (src_sel == st_q.src);
        edge_hit  = src_same && sel_line && !st_q.prev;
        cnt_lim   = fast_mode ? CNT_W'(FAST_DEPTH) : CNT_W'(1);

        st_d      = st_q;
        st_d.src  = src_sel;
        st_d.prev = sel_line;
        if (grant && (st_q.cnt != '0))
            st_d.cnt = st_q.cnt - 1'b1;
        if (edge_hit && (st_d.cnt < cnt_lim))
            st_d.cnt = st_d.cnt + 1'b1;
        st_d.rdy = fast_mode &&
                   (grant || (!edge_hit && (st_q.rdy || (st_q.cnt == '0))));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig     = (st_q.cnt != '0);
    assign fast_rdy = st_q.rdy;

    AST_HOLD_TILL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !grant) |=> trig); // R7
    AST_RDY_ONLY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_mode |=> !fast_rdy); // R9
    AST_PULSE_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_mode && edge_hit && !grant) |=> !fast_rdy); // R10
    AST_GRANT_RAISES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_mode && grant) |=> fast_rdy); // R10
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FAST_DEPTH)); // R11

endmodule

// File: rtl/dma_trig_select.sv
module dma_trig_select #(
    parameter int          N_EXT      = 4,
    parameter int          N_CHAN     = 6,
    parameter int          N_PERIPH   = 13,
    parameter int          SRC_W      = 5,
    parameter int          FAST_DEPTH = 3,
    parameter logic [31:0] FAST_MASK  = 32'h003C_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    src_sel,
    input  logic [2:0]          xfer_mode,
    input  logic [N_EXT-1:0]    ext_req,
    input  logic [N_CHAN-1:0]   chan_done,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic                grant,
    output logic                trig,
    output logic                fast_rdy
);
    localparam int N_SRC = N_EXT + N_CHAN + N_PERIPH;

    logic sel_line;
    logic fast_cap;

    dma_src_mux #(
        .N_EXT    (N_EXT),
        .N_CHAN   (N_CHAN),
        .N_PERIPH (N_PERIPH),
        .SRC_W    (SRC_W),
        .FAST_MASK(FAST_MASK)
    ) u_mux (
        .ext_req   (ext_req),
        .chan_done (chan_done),
        .periph_req(periph_req),
        .src_sel   (src_sel),
        .sel_line  (sel_line),
        .fast_cap  (fast_cap)
    );

    dma_trig_ctrl #(
        .SRC_W     (SRC_W),
        .FAST_DEPTH(FAST_DEPTH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .sel_line (sel_line),
        .fast_cap (fast_cap),
        .xfer_mode(xfer_mode),
        .grant    (grant),
        .trig     (trig),
        .fast_rdy (fast_rdy)
    );

    AST_RISE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(sel_line)); // R5
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(src_sel) >= N_SRC) && !trig) |=> !trig); // R4

endmodule

// File: tb/sim_dma_trig_select.sv
module sim_dma_trig_select;
    localparam time CLK_T = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  src_sel;
    logic [2:0]  xfer_mode;
    logic [3:0]  ext_req;
    logic [5:0]  chan_done;
    logic [12:0] periph_req;
    logic        grant;
    logic        trig;
    logic        fast_rdy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    dma_trig_select u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .xfer_mode(xfer_mode),
        .ext_req(ext_req), .chan_done(chan_done), .periph_req(periph_req),
        .grant(grant), .trig(trig), .fast_rdy(fast_rdy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic all_lines(input logic v);
        ext_req = {4{v}}; chan_done = {6{v}}; periph_req = {13{v}};
    endtask

    task automatic set_line(input int code, input logic v);
        if (code < 4)       ext_req[code]       = v;
        else if (code < 10) chan_done[code-4]   = v;
        else if (code < 23) periph_req[code-10] = v;
    endtask

    task automatic select(input int code);
        src_sel = 5'(code);
        tick(); tick();
    endtask

    task automatic do_grant();
        grant = 1'b1; tick(); grant = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; src_sel = '0; xfer_mode = '0; grant = 1'b0;
        all_lines(1'b0);
        repeat (3) tick();
        chk(trig, 1'b0, "R1 trig in reset");
        chk(fast_rdy, 1'b0, "R1 rdy in reset");
        rst_n = 1'b1;
        tick();
        chk(trig, 1'b0, "R1 trig after reset");
        chk(fast_rdy, 1'b0, "R1 rdy after reset");
    endtask

    task automatic one_source(input int code, input string tag);
        all_lines(1'b0);
        select(code);
        set_line((code + 1) % 23, 1'b1);
        tick();
        chk(trig, 1'b0, {tag, " unselected line"});
        set_line(code, 1'b1);
        tick();
        chk(trig, 1'b1, {tag, " selected edge"});
        tick();
        chk(trig, 1'b1, "R7 held before grant");
        do_grant();
        chk(trig, 1'b0, "R7 cleared by grant");
        tick();
        chk(trig, 1'b0, "R5 no retrigger while high");
        all_lines(1'b0);
        tick();
    endtask

    task automatic t_ext();
        for (int c = 0; c < 4; c++) one_source(c, "R2");
    endtask

    task automatic t_chan();
        for (int c = 4; c < 10; c++) one_source(c, "R3");
    endtask

    task automatic t_periph();
        for (int c = 10; c < 23; c++) one_source(c, "R4");
    endtask

    task automatic t_reserved();
        for (int c = 23; c < 32; c++) begin
            all_lines(1'b0);
            select(c);
            all_lines(1'b1);
            tick();
            chk(trig, 1'b0, "R4 reserved code");
            all_lines(1'b0);
            tick();
        end
    endtask

    task automatic t_src_change();
        all_lines(1'b0);
        select(0);
        ext_req[2] = 1'b1;
        tick();
        src_sel = 5'd2;
        tick();
        chk(trig, 1'b0, "R6 switch onto high line");
        tick();
        chk(trig, 1'b0, "R6 no late trigger");
        all_lines(1'b0);
        tick();
    endtask

    task automatic t_merge();
        all_lines(1'b0);
        select(1);
        ext_req[1] = 1'b1; tick();
        ext_req[1] = 1'b0; tick();
        ext_req[1] = 1'b1; tick();
        chk(trig, 1'b1, "R8 pending after two edges");
        ext_req[1] = 1'b0;
        do_grant();
        chk(trig, 1'b0, "R8 one grant clears merged edges");
    endtask

    task automatic pulse(input int code);
        set_line(code, 1'b1); tick(); set_line(code, 1'b0);
    endtask

    task automatic t_fast();
        all_lines(1'b0);
        xfer_mode = 3'b001;
        select(18);
        chk(fast_rdy, 1'b1, "R9 ready in fast mode");
        pulse(18);
        chk(trig, 1'b1, "R5 fast pulse triggers");
        chk(fast_rdy, 1'b0, "R10 pulse drops ready");
        tick();
        chk(fast_rdy, 1'b0, "R10 ready stays low until grant");
        do_grant();
        chk(trig, 1'b0, "R7 fast grant clears");
        chk(fast_rdy, 1'b1, "R10 grant raises ready");
        pulse(18);
        tick();
        pulse(18);
        chk(trig, 1'b1, "R11 two pulses pending");
        do_grant();
        chk(trig, 1'b1, "R11 second pulse kept");
        chk(fast_rdy, 1'b1, "R10 ready after grant");
        do_grant();
        chk(trig, 1'b0, "R11 second grant clears");
        xfer_mode = 3'b101;
        select(21);
        chk(fast_rdy, 1'b1, "R9 second word mode");
        xfer_mode = 3'b001;
        select(10);
        chk(fast_rdy, 1'b0, "R9 source without fast mask");
    endtask

    task automatic t_fast_off();
        all_lines(1'b0);
        xfer_mode = 3'b010;
        select(18);
        chk(fast_rdy, 1'b0, "R12 no ready in block mode");
        pulse(18);
        tick();
        pulse(18);
        chk(trig, 1'b1, "R12 pending");
        do_grant();
        chk(trig, 1'b0, "R12 pulses merged");
        xfer_mode = 3'b000;
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ext();
        t_chan();
        t_periph();
        t_reserved();
        t_src_change();
        t_merge();
        t_fast();
        t_fast_off();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule